// File: doc/BRIEF.md
# CRC-32 Byte Engine

This block folds a byte stream into a 32-bit cyclic redundancy check. It takes one byte per clock cycle. Each accepted byte updates a running 32-bit remainder through a 256-entry lookup table, and the table is computed at elaboration from the generator polynomial. The update is written in the most-significant-bit-first form. Each incoming byte has its bit order reversed before it takes part in the update. When a message ends, the whole remainder is bit-reversed and combined with a fixed output mask.

A producer presents bytes with a valid/ready handshake. It marks the first byte of a message with a start flag and the final byte with a last flag. The checksum is registered and appears together with a one-cycle result strobe. The checksum stays on the output until the next message completes.

Top module: `crc32_byte_engine`

## Requirements
- R1: Under reset, and in the first cycle after it, `res_valid` is 0 and `byte_ready` is 1. The remainder resets to the initial value 0xFFFFFFFF, so a message sent after reset without a start flag yields the standard checksum.
- R2: `byte_ready` is 0 in the cycle where `res_valid` is 1, and 1 in every other cycle. A byte offered while `byte_ready` is 0 is ignored: it does not change the remainder and does not produce a result.
- R3: A byte accepted with `byte_first` = 1 is folded into the initial value 0xFFFFFFFF instead of the current remainder. Bytes accepted earlier without a last flag have no effect on the checksum.
- R4: The engine accepts one byte per cycle. The update uses the polynomial 0x04C11DB7. The table index is the bit-reversed byte (data bit 0 goes to index bit 7) XORed with remainder bits 31:24. The new remainder is that table entry XORed with the remainder shifted left by 8.
- R5: The checksum is the bit-reversed remainder (bit 0 goes to bit 31) XORed with 0xFFFFFFFF. The ASCII string "123456789" gives 0xCBF43926.
- R6: `res_valid` is high for exactly one cycle: the cycle that follows the clock edge that accepted the byte flagged last. `res_crc` holds its value in every cycle where `res_valid` is 0.
- R7: In cycles where `byte_valid` is 0 the remainder does not change. Idle gaps inside a message therefore do not alter its checksum.
- R8: A single byte that carries both the start and the last flag forms a complete message.
- R9: Bytes accepted after a result without a start flag continue from the remainder left by the previous message. For example, "a" followed by "bc" without a start flag gives the checksum of "abc", 0x352441C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A byte is offered |
| byte_ready | output | 1 | The engine can take a byte this cycle |
| byte_data | input | 8 | Byte value |
| byte_first | input | 1 | The offered byte starts a message |
| byte_final | input | 1 | The offered byte ends a message |
| res_valid | output | 1 | One-cycle strobe: checksum is new |
| res_crc | output | 32 | Checksum of the last completed message |

## Verification
The embedded properties assume that `byte_valid`, `byte_first` and `byte_final` carry known values on every clock edge after reset. They also assume that no byte is expected to be taken while `byte_ready` is low. The bench meets both conditions by driving every input to a defined level from time zero and changing inputs only at falling edges. The single deliberate breach is a byte offered during the result cycle: the bench expects that byte to be dropped and checks at the ports that it was. The bench's expected checksums are well-known values for short strings and constant words, and the chaining tests are arranged so that they reduce to one of those strings.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

  localparam int unsigned CRC_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LUT_DEPTH = 1 << BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // One table word: index in the top byte, then eight MSB-first division steps.
  function automatic crc_t lut_word(input int unsigned idx, input crc_t poly);
    crc_t acc;
    acc = crc_t'(idx) << (CRC_W - BYTE_W);
    for (int s = 0; s < int'(BYTE_W); s++) begin
      if (acc[CRC_W-1]) acc = (acc << 1) ^ poly;
      else              acc = acc << 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/crc_bit_reflect.sv
module crc_bit_reflect #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_swap
    assign dout[b] = din[W-1-b];
  end

endmodule

// File: rtl/crc_lut_rom.sv
module crc_lut_rom #(
  parameter crc32_pkg::crc_t POLY = 32'h04C1_1DB7
) (
  input  crc32_pkg::byte_t idx,
  output crc32_pkg::crc_t  word_o
);

  crc32_pkg::crc_t lut [crc32_pkg::LUT_DEPTH];

  for (genvar i = 0; i < crc32_pkg::LUT_DEPTH; i++) begin : g_entry
    assign lut[i] = crc32_pkg::lut_word(i, POLY);
  end

  assign word_o = lut[idx];

endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
  parameter crc32_pkg::crc_t XOR_OUT = 32'hFFFF_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  crc32_pkg::crc_t rem_fin,
  output logic            res_valid,
  output crc32_pkg::crc_t res_crc
);

  crc32_pkg::crc_t rem_refl;
  crc32_pkg::crc_t res_d;

  crc_bit_reflect #(.W(crc32_pkg::CRC_W)) u_refl_rem (
    .din (rem_fin),
    .dout(rem_refl)
  );

  always_comb begin
    res_d = rem_refl ^ XOR_OUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_crc   <= '0;
    end else begin
      res_valid <= load;
      if (load) res_crc <= res_d;
    end
  end

  // R6: the checksum only moves together with the result strobe
  p_crc_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_crc));

endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine #(
  parameter crc32_pkg::crc_t POLY     = 32'h04C1_1DB7,
  parameter crc32_pkg::crc_t INIT     = 32'hFFFF_FFFF,
  parameter crc32_pkg::crc_t XOR_OUT  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  input  logic        byte_first,
  input  logic        byte_final,
  output logic        res_valid,
  output logic [31:0] res_crc
);

  localparam int unsigned TOP_LSB = crc32_pkg::CRC_W - crc32_pkg::BYTE_W;

  crc32_pkg::crc_t  rem_q, rem_d, base, step, lut_val;
  crc32_pkg::byte_t data_refl, lut_idx;
  logic             fire, rem_en;

  assign byte_ready = !res_valid;
  assign fire       = byte_valid && byte_ready;

  crc_bit_reflect #(.W(crc32_pkg::BYTE_W)) u_refl_in (
    .din (byte_data),
    .dout(data_refl)
  );

  always_comb begin
    base    = byte_first ? INIT : rem_q;
    lut_idx = data_refl ^ base[crc32_pkg::CRC_W-1:TOP_LSB];
  end

  crc_lut_rom #(.POLY(POLY)) u_lut (
    .idx   (lut_idx),
    .word_o(lut_val)
  );

  always_comb begin
    step   = lut_val ^ (base << crc32_pkg::BYTE_W);
    rem_en = fire;
    rem_d  = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= INIT;
    else if (rem_en) rem_q <= rem_d;
  end

  crc_out_stage #(.XOR_OUT(XOR_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire && byte_final),
    .rem_fin  (step),
    .res_valid(res_valid),
    .res_crc  (res_crc)
  );

  // R7: remainder frozen while no byte is taken
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && byte_ready) |=> rem_q == $past(rem_q));

  // R6: result strobe follows an accepted last byte
  p_result_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready && byte_final) |=> res_valid);

  // R6: strobe never lasts two cycles
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2: the engine is ready again right after the result cycle
  p_ready_after_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> byte_ready);

endmodule

// File: tb/crc32_byte_engine_tb_top.sv
module crc32_byte_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid, byte_first, byte_final;
  logic [7:0]  byte_data;
  logic        byte_ready, res_valid;
  logic [31:0] res_crc;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  crc32_byte_engine dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_valid(byte_valid),
    .byte_ready(byte_ready),
    .byte_data (byte_data),
    .byte_first(byte_first),
    .byte_final(byte_final),
    .res_valid (res_valid),
    .res_crc   (res_crc)
  );

  typedef struct packed {
    logic [95:0] msg;
    logic [7:0]  len;
    logic [31:0] crc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{msg: 96'("123456789"),  len: 8'd9, crc: 32'hCBF4_3926},
    '{msg: 96'("a"),          len: 8'd1, crc: 32'hE8B7_BE43},
    '{msg: 96'("abc"),        len: 8'd3, crc: 32'h3524_41C2},
    '{msg: 96'h00,            len: 8'd1, crc: 32'hD202_EF8D},
    '{msg: 96'h0000_0000,     len: 8'd4, crc: 32'h2144_DF1C},
    '{msg: 96'hFFFF_FFFF,     len: 8'd4, crc: 32'hFFFF_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic l);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; byte_first = s; byte_final = l;
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid = 1'b0; byte_first = 1'b0; byte_final = 1'b0;
  endtask

  // idle at the next falling edge, then look at the result cycle and the one after
  task automatic expect_result(input string req, input logic [31:0] exp);
    idle();
    chk(req, {31'd0, res_valid}, 32'd1);
    chk(req, res_crc, exp);
    @(negedge clk);
    chk("R6 pulse width", {31'd0, res_valid}, 32'd0);
    chk("R6 hold", res_crc, exp);
  endtask

  task automatic send_msg(input logic [95:0] m, input int len, input logic with_start, input int gap);
    for (int i = 0; i < len; i++) begin
      put(m[8*(len-1-i) +: 8], with_start && (i == 0), i == len-1);
      if (gap > 0 && i != len-1) begin
        for (int g = 0; g < gap; g++) idle();
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_first = 1'b0; byte_final = 1'b0; byte_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, res_valid}, 32'd0);
    chk("R1 ready in reset", {31'd0, byte_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R1 ready after reset", {31'd0, byte_ready}, 32'd1);

    // R1: message with no start flag relies on the reset remainder
    send_msg(96'("123456789"), 9, 1'b0, 0);
    expect_result("R1 reset remainder", 32'hCBF4_3926);

    // R4 R5 R8: table walk, back-to-back bytes
    for (int v = 0; v < NVEC; v++) begin
      send_msg(VECS[v].msg, int'(VECS[v].len), 1'b1, 0);
      expect_result(VECS[v].len == 8'd1 ? "R8 single byte" : "R4/R5 vector", VECS[v].crc);
    end

    // R7: idle gaps inside a message
    send_msg(96'("123456789"), 9, 1'b1, 2);
    expect_result("R7 gaps", 32'hCBF4_3926);

    // R3: stray bytes then a start flag
    put(8'hDE, 1'b0, 1'b0);
    put(8'hAD, 1'b0, 1'b0);
    idle();
    send_msg(96'("abc"), 3, 1'b1, 0);
    expect_result("R3 start reload", 32'h3524_41C2);

    // R2 R9: byte offered in the result cycle is dropped; chaining without start
    put(8'h61, 1'b1, 1'b1);
    @(negedge clk);
    byte_data = 8'h55; byte_first = 1'b1; byte_final = 1'b1;
    chk("R2 result strobe", {31'd0, res_valid}, 32'd1);
    chk("R2 ready low", {31'd0, byte_ready}, 32'd0);
    chk("R2 checksum a", res_crc, 32'hE8B7_BE43);
    idle();
    chk("R2 ignored byte no result", {31'd0, res_valid}, 32'd0);
    chk("R2 ready restored", {31'd0, byte_ready}, 32'd1);
    chk("R6 hold after ignored", res_crc, 32'hE8B7_BE43);
    send_msg(96'("bc"), 2, 1'b0, 0);
    expect_result("R9 chained / R2 ignored", 32'h3524_41C2);

    // R6: back-to-back single byte messages
    put(8'h00, 1'b1, 1'b1);
    expect_result("R6 back to back", 32'hD202_EF8D);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule